// File: doc/BRIEF.md
# Coprocessor Error Interrupt and Ignore Control

This block sits between a system controller and a processor and handles legacy floating-point error signalling. The processor reports a numeric fault on an active-low error line. When reporting is enabled, the block turns that line into a level request on interrupt line 13, which goes to an interrupt controller outside the block. It also drives an active-low ignore-error line back to the processor.

Software acknowledges a fault by writing to I/O port F0h. Bus decoding outside the block turns that write into a one-cycle strobe. If the strobe arrives while the error is active, the block asserts the ignore line. The ignore line then holds until the processor withdraws the error. A single configuration bit turns the whole function on or off. The error line is asynchronous and is synchronised before any use. All other inputs are in the block's clock domain. No data moves through the block, so every pin is a plain level or strobe with no handshake.

Top module: `fpe_err_ctrl`

## Requirements
- R1: While the synchronous active-low reset `rst_n` is low, and in the cycle after it, `irq13_req` reads 0 and `ignore_n` reads 1.
- R2: `err_n_async` (0 = error) passes through a two-flop synchroniser. A change on it reaches the outputs only after the second rising clock edge, never after the first.
- R3: `irq13_req` is a level, not a pulse. It equals 1 exactly while `rpt_en` is 1 and the synchronised error is active.
- R4: A `port_f0_wr` pulse sampled while `rpt_en` is 1 and the synchronised error is active drives `ignore_n` to 0 from the next rising edge.
- R5: A `port_f0_wr` pulse sampled while the synchronised error is inactive has no effect. `ignore_n` stays 1, even after the error later becomes active.
- R6: Once set, `ignore_n` stays 0 until the synchronised error goes inactive. It then returns to 1 in the same cycle that `irq13_req` falls. It does not return to 0 on a later error unless a new write arrives.
- R7: `rpt_en` = 0 forces `irq13_req` to 0 and `ignore_n` to 1 in the same cycle, and it clears the held ignore state. Setting `rpt_en` back to 1 restores `irq13_req` but not `ignore_n`.
- R8: A `port_f0_wr` pulse sampled while `rpt_en` is 0 is ignored. `ignore_n` stays 1 after reporting is re-enabled with the error still active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| err_n_async | input | 1 | Processor numeric error, active low, asynchronous |
| rpt_en | input | 1 | Configuration bit enabling error reporting |
| port_f0_wr | input | 1 | One-cycle strobe for a write to I/O port F0h |
| irq13_req | output | 1 | Level request on interrupt line 13 |
| ignore_n | output | 1 | Ignore-numeric-error output to the processor, active low |

## Verification
An edge on the error input shows on `irq13_req` after the second rising edge, and a release on `ignore_n` also after the second edge. A port write shows on `ignore_n` after one edge. A change of `rpt_en` acts in the same cycle, with no edge between. The bench drives all inputs just after the falling edge. It compares the outputs one time unit later, against a cycle model that it advances at each rising edge. In that way each result is checked in exactly the cycle it is due, and never a cycle early or late.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  localparam int unsigned FPE_SYNC_MIN = 2;

  typedef enum logic {
    IGN_IDLE = 1'b0,
    IGN_HELD = 1'b1
  } ign_state_e;
endpackage

// File: rtl/fpe_sync.sv
module fpe_sync #(
  parameter int unsigned STAGES  = fpe_pkg::FPE_SYNC_MIN,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[LAST-1:0], d_async};
  end

  assign q_sync = chain_q[LAST];

  generate
    for (genvar g = 1; g < int'(STAGES); g++) begin : g_stage_chk
      assert_stage_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        chain_q[g] == $past(chain_q[g-1]))
        else $error("synchroniser stage %0d did not follow its predecessor", g);
    end
  endgenerate
endmodule

// File: rtl/fpe_ign_latch.sv
module fpe_ign_latch
  import fpe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rpt_en,
  input  logic err_act,
  input  logic wr_pulse,
  output logic held
);
  ign_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!rpt_en) begin
      state_d = IGN_IDLE;
    end else begin
      unique case (state_q)
        IGN_IDLE: if (wr_pulse && err_act) state_d = IGN_HELD;
        IGN_HELD: if (!err_act)            state_d = IGN_IDLE;
        default:                           state_d = IGN_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= IGN_IDLE;
    else        state_q <= state_d;
  end

  assign held = (state_q == IGN_HELD);

  assert_set_by_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> $past(wr_pulse && err_act && rpt_en))
    else $error("ignore latch set without a qualifying write");

  assert_no_set_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!held && !(wr_pulse && err_act)) |=> !held)
    else $error("ignore latch set with no error-time write");

  assert_hold_while_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (held && err_act && rpt_en) |=> held)
    else $error("ignore latch dropped while error still active");

  assert_disable_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rpt_en |=> !held)
    else $error("ignore latch survived disable");
endmodule

// File: rtl/fpe_out_gate.sv
module fpe_out_gate (
  input  logic rpt_en,
  input  logic err_act,
  input  logic held,
  output logic irq_lvl,
  output logic ign_n
);
  always_comb begin
    irq_lvl = rpt_en & err_act;
    ign_n   = ~(rpt_en & err_act & held);
  end
endmodule

// File: rtl/fpe_err_ctrl.sv
module fpe_err_ctrl #(
  parameter int unsigned SYNC_STAGES = fpe_pkg::FPE_SYNC_MIN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic err_n_async,
  input  logic rpt_en,
  input  logic port_f0_wr,
  output logic irq13_req,
  output logic ignore_n
);
  logic err_n_sync;
  logic err_act;
  logic ign_held;

  fpe_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(err_n_async),
    .q_sync (err_n_sync)
  );

  assign err_act = ~err_n_sync;

  fpe_ign_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .rpt_en  (rpt_en),
    .err_act (err_act),
    .wr_pulse(port_f0_wr),
    .held    (ign_held)
  );

  fpe_out_gate u_gate (
    .rpt_en (rpt_en),
    .err_act(err_act),
    .held   (ign_held),
    .irq_lvl(irq13_req),
    .ign_n  (ignore_n)
  );

  assert_ign_needs_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ignore_n |-> ign_held)
    else $error("ignore output active without latch");

  assert_ign_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ignore_n |-> irq13_req)
    else $error("ignore output active while no error is reported");

  assert_disable_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rpt_en |-> (!irq13_req && ignore_n))
    else $error("outputs active while reporting disabled");

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> ignore_n)
    else $error("ignore output active after reset");
endmodule

// File: tb/test_fpe_err_ctrl.sv
module test_fpe_err_ctrl;
  logic clk = 1'b0;
  logic rst_n, err_n, en, wr;
  logic irq, ign_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic m_s1, m_s2, m_held;

  always #4 clk = ~clk;

  fpe_err_ctrl i_fpe_err_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_n_async(err_n),
    .rpt_en     (en),
    .port_f0_wr (wr),
    .irq13_req  (irq),
    .ignore_n   (ign_n)
  );

  function automatic logic exp_irq();
    return en & m_s2;
  endfunction

  function automatic logic exp_ign_n();
    return ~(en & m_s2 & m_held);
  endfunction

  task automatic chk(input string tag, input string what, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic e_n, input logic e, input logic w,
                      input string tag);
    logic nh;
    @(negedge clk);
    rst_n = r; err_n = e_n; en = e; wr = w;
    #1;
    chk(tag, "irq13_req", irq, exp_irq());
    chk(tag, "ignore_n", ign_n, exp_ign_n());
    @(posedge clk);
    if (!rst_n) begin
      m_s1 = 1'b0; m_s2 = 1'b0; m_held = 1'b0;
    end else begin
      if (!en)        nh = 1'b0;
      else if (m_held) nh = m_s2;
      else            nh = wr & m_s2;
      m_held = nh;
      m_s2 = m_s1;
      m_s1 = ~err_n;
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic re, rw, ren;
    void'($urandom(32'd2024));
    rst_n = 1'b0; err_n = 1'b1; en = 1'b1; wr = 1'b0;
    m_s1 = 1'b0; m_s2 = 1'b0; m_held = 1'b0;
    repeat (3) @(posedge clk);
    step(0, 0, 1, 1, "R1");
    step(0, 0, 1, 1, "R1");
    step(1, 1, 1, 0, "R1");
    step(1, 1, 1, 0, "R1");
    step(1, 1, 1, 0, "R1");

    // R2: error reaches irq only after two edges
    step(1, 0, 1, 0, "R2");
    step(1, 0, 1, 0, "R2");
    step(1, 0, 1, 0, "R2");
    repeat (3) step(1, 0, 1, 0, "R3");

    // R4: write while error active
    step(1, 0, 1, 1, "R4");
    step(1, 0, 1, 0, "R4");
    step(1, 0, 1, 0, "R4");

    // R6: release follows error negation, no re-set without write
    repeat (4) step(1, 1, 1, 0, "R6");
    repeat (4) step(1, 0, 1, 0, "R6");

    // R5: write while error inactive
    repeat (3) step(1, 1, 1, 0, "R5");
    step(1, 1, 1, 1, "R5");
    repeat (5) step(1, 0, 1, 0, "R5");

    // R7: disable clears immediately and forgets the latch
    step(1, 0, 1, 1, "R7");
    step(1, 0, 1, 0, "R7");
    step(1, 0, 0, 0, "R7");
    step(1, 0, 0, 0, "R7");
    repeat (3) step(1, 0, 1, 0, "R7");

    // R8: write while disabled
    step(1, 0, 0, 1, "R8");
    step(1, 0, 0, 0, "R8");
    repeat (3) step(1, 0, 1, 0, "R8");

    // random mix
    re = 1'b1; ren = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 8) == 0)  re = ~re;
      if (($urandom % 40) == 0) ren = ~ren;
      rw = (($urandom % 4) == 0);
      step(1, re, ren, rw, (i % 2 == 0) ? "R3" : "R6");
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule